// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a freshly powered SDRAM device into a usable state. It leaves reset in a quiet wait. During the wait, clock enable and every byte mask are high and the command pins carry only NOP. Once a stable-power interval has passed, the block issues a precharge that covers all banks. It then issues a run of auto-refresh commands and loads the mode register, in an order chosen by a parameter. Finally it raises a ready flag that stays high.

The caller supplies the mode word on `mode_cfg`. The block cleans this word before it is put on the address pins. Bits the device keeps reserved or uses for test are forced to zero, and a reserved CAS-latency code is replaced by a legal one. Every timing value is a parameter. The stable-power wait is given in microseconds and scaled by the clock frequency in MHz. The gaps after each command are given in clock cycles. Each command occupies exactly one cycle.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, the pins show NOP (chip select low; row strobe, column strobe and write enable high) and `init_done` is low.
- R2: After reset release, exactly CLK_MHZ*WAIT_US cycles of NOP pass before the first non-NOP command.
- R3: The first command is a precharge: chip select low, row strobe low, column strobe high, write enable low, with address bit 10 high so that it covers all banks.
- R4: Each command is followed by exactly its own number of NOP cycles before the next command or the ready state: T_RP after precharge, T_RFC after each refresh, T_MRD after mode set.
- R5: Auto-refresh is chip select, row strobe and column strobe low with write enable high, and it is issued exactly REFRESH_COUNT times.
- R6: A REFRESH_COUNT below 2 is raised to 2, so the ready flag never rises with fewer than two refreshes behind it.
- R7: Mode set is chip select, row strobe, column strobe and write enable all low, and it is issued exactly once. During it, the bank lines and address bits 10, 8 and 7 are zero.
- R8: During mode set, address bits 6..4 carry the CAS-latency code. The codes 3'b010 (latency 2) and 3'b011 (latency 3) pass unchanged, and any other code is sent as 3'b011. Address bits 9 and 3..0 copy `mode_cfg`.
- R9: With MRS_FIRST=0 all refreshes come before the mode set. With MRS_FIRST=1 the mode set comes directly after the precharge gap, and the refreshes follow it.
- R10: `init_done` rises in the cycle after the last gap ends and then stays high while the pins stay at NOP.
- R11: `sd_cke` and every `sd_dqm` bit are high in every cycle, during reset and after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_cfg | input | 11 | Requested mode word, cleaned before it is driven |
| sd_cke | output | 1 | Clock enable to the device |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm | output | DQM_W | Byte masks, held high |
| sd_addr | output | 11 | Multiplexed address lines |
| sd_ba | output | 2 | Bank select lines |
| init_done | output | 1 | High once the sequence is finished |

## Verification
The command pins are decoded directly from the sequencer state. A wrong state therefore shows up in the same cycle as a wrong or missing command pattern, or as a ready flag at the wrong time. An off-by-one in the shared down-counter moves the next command by one or more cycles. This is visible at the next command edge, at most one gap length after the fault. A fault in the refresh or mode-set bookkeeping changes the command counts and the index at which ready rises, so it is exposed by the end of the sequence.

// File: rtl/sdinit_pkg.sv
`timescale 1ns/1ps
package sdinit_pkg;

  localparam int MODE_W = 11;
  localparam int BANK_W = 2;
  localparam int AP_BIT = 10;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_REF = 2'd2,
    CMD_MRS = 2'd3
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT    = 3'd0,
    ST_PRE     = 3'd1,
    ST_PRE_GAP = 3'd2,
    ST_REF     = 3'd3,
    ST_REF_GAP = 3'd4,
    ST_MRS     = 3'd5,
    ST_MRS_GAP = 3'd6,
    ST_DONE    = 3'd7
  } seq_state_e;

  // Zero the reserved and test-mode bits, and replace a reserved latency code with 3.
  function automatic logic [MODE_W-1:0] clean_mode(input logic [MODE_W-1:0] raw);
    logic [MODE_W-1:0] r;
    r      = raw;
    r[10]  = 1'b0;
    r[8:7] = 2'b00;
    if (raw[6:4] != 3'b010 && raw[6:4] != 3'b011)
      r[6:4] = 3'b011;
    return r;
  endfunction

endpackage

// File: rtl/sdinit_timer.sv
`timescale 1ns/1ps
module sdinit_timer #(
  parameter int CNT_W    = 8,
  parameter int INIT_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= CNT_W'(INIT_VAL);
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sdinit_cmd_enc.sv
`timescale 1ns/1ps
module sdinit_cmd_enc
  import sdinit_pkg::*;
(
  input  sd_cmd_e            cmd,
  input  logic [MODE_W-1:0]  mode_word,
  output logic               cs_n,
  output logic               ras_n,
  output logic               cas_n,
  output logic               we_n,
  output logic [MODE_W-1:0]  addr,
  output logic [BANK_W-1:0]  ba
);

  always_comb begin
    cs_n  = 1'b0;
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    addr  = '0;
    ba    = '0;
    case (cmd)
      CMD_PRE: begin
        ras_n        = 1'b0;
        we_n         = 1'b0;
        addr[AP_BIT] = 1'b1;
      end
      CMD_REF: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
      end
      CMD_MRS: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
        we_n  = 1'b0;
        addr  = clean_mode(mode_word);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sdram_powerup_seq.sv
`timescale 1ns/1ps
module sdram_powerup_seq
  import sdinit_pkg::*;
#(
  parameter int CLK_MHZ       = 125,
  parameter int WAIT_US       = 200,
  parameter int T_RP          = 3,
  parameter int T_RFC         = 9,
  parameter int T_MRD         = 2,
  parameter int REFRESH_COUNT = 8,
  parameter int MRS_FIRST     = 0,
  parameter int DQM_W         = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [10:0]       mode_cfg,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic [10:0]       sd_addr,
  output logic [1:0]        sd_ba,
  output logic              init_done
);

  localparam int WAIT_RAW = CLK_MHZ * WAIT_US;
  localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
  localparam int RP       = (T_RP  < 1) ? 1 : T_RP;
  localparam int RFC      = (T_RFC < 1) ? 1 : T_RFC;
  localparam int MRD      = (T_MRD < 1) ? 1 : T_MRD;
  localparam int REF_N    = (REFRESH_COUNT < 2) ? 2 : REFRESH_COUNT;
  localparam int REF_W    = $clog2(REF_N + 1);
  localparam int MAX_A    = (WAIT_CYC > RP) ? WAIT_CYC : RP;
  localparam int MAX_B    = (RFC > MRD) ? RFC : MRD;
  localparam int MAX_V    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_V + 1);

  seq_state_e       state, nxt;
  logic [REF_W-1:0] refs_done;
  logic             mrs_done;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  sd_cmd_e          cmd;

  // Internal events brought out for the checker.
  logic ev_pre, ev_ref, ev_mrs;
  assign ev_pre = (state == ST_PRE);
  assign ev_ref = (state == ST_REF);
  assign ev_mrs = (state == ST_MRS);

  function automatic seq_state_e pick_next(input logic m_done, input logic [REF_W-1:0] r_done);
    if (MRS_FIRST != 0 && !m_done)  return ST_MRS;
    if (r_done < REF_W'(REF_N))     return ST_REF;
    if (!m_done)                    return ST_MRS;
    return ST_DONE;
  endfunction

  sdinit_timer #(.CNT_W(CNT_W), .INIT_VAL(WAIT_CYC - 1)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_WAIT:    if (tmr_zero) nxt = ST_PRE;
      ST_PRE: begin
        nxt = ST_PRE_GAP; tmr_load = 1'b1; tmr_val = CNT_W'(RP - 1);
      end
      ST_REF: begin
        nxt = ST_REF_GAP; tmr_load = 1'b1; tmr_val = CNT_W'(RFC - 1);
      end
      ST_MRS: begin
        nxt = ST_MRS_GAP; tmr_load = 1'b1; tmr_val = CNT_W'(MRD - 1);
      end
      ST_PRE_GAP, ST_REF_GAP, ST_MRS_GAP:
        if (tmr_zero) nxt = pick_next(mrs_done, refs_done);
      ST_DONE:    nxt = ST_DONE;
      default:    nxt = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_WAIT;
      refs_done <= '0;
      mrs_done  <= 1'b0;
    end else begin
      state <= nxt;
      if (ev_ref) refs_done <= refs_done + 1'b1;
      if (ev_mrs) mrs_done  <= 1'b1;
    end
  end

  always_comb begin
    case (state)
      ST_PRE:  cmd = CMD_PRE;
      ST_REF:  cmd = CMD_REF;
      ST_MRS:  cmd = CMD_MRS;
      default: cmd = CMD_NOP;
    endcase
  end

  sdinit_cmd_enc u_enc (
    .cmd       (cmd),
    .mode_word (mode_cfg),
    .cs_n      (sd_cs_n),
    .ras_n     (sd_ras_n),
    .cas_n     (sd_cas_n),
    .we_n      (sd_we_n),
    .addr      (sd_addr),
    .ba        (sd_ba)
  );

  assign sd_cke    = 1'b1;
  assign sd_dqm    = '1;
  assign init_done = (state == ST_DONE);

endmodule

// File: rtl/sdinit_chk.sv
`timescale 1ns/1ps
module sdinit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [10:0] addr,
  input logic [1:0]  ba,
  input logic        init_done,
  input logic        ev_pre,
  input logic        ev_ref,
  input logic        ev_mrs
);

  logic pin_nop, pin_pre, pin_ref, pin_mrs;
  assign pin_nop = !cs_n && ras_n && cas_n && we_n;
  assign pin_pre = !cs_n && !ras_n && cas_n && !we_n;
  assign pin_ref = !cs_n && !ras_n && !cas_n && we_n;
  assign pin_mrs = !cs_n && !ras_n && !cas_n && !we_n;

  logic [7:0] ref_seen;
  logic       mrs_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_seen <= '0;
      mrs_seen <= 1'b0;
    end else begin
      if (pin_ref && ref_seen != 8'hFF) ref_seen <= ref_seen + 1'b1;
      if (pin_mrs) mrs_seen <= 1'b1;
    end
  end

  // R3
  pre_all_banks_chk: assert property (@(posedge clk) disable iff (!rst_n) pin_pre |-> addr[10]);
  // R3
  pre_event_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_pre |-> pin_pre);
  // R5
  ref_event_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_ref |-> pin_ref);
  // R7
  mrs_event_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_mrs |-> pin_mrs);
  // R7
  mrs_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_mrs |-> (!addr[10] && addr[8:7] == 2'b00 && ba == 2'b00));
  // R8
  mrs_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_mrs |-> (addr[6:4] == 3'b010 || addr[6:4] == 3'b011));
  // R4
  cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pre || pin_ref || pin_mrs) |=> pin_nop);
  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) init_done |=> init_done);
  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) init_done |-> pin_nop);
  // R6
  done_after_refs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (ref_seen >= 8'd2 && mrs_seen));

endmodule

bind sdram_powerup_seq sdinit_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (sd_cs_n),
  .ras_n     (sd_ras_n),
  .cas_n     (sd_cas_n),
  .we_n      (sd_we_n),
  .addr      (sd_addr),
  .ba        (sd_ba),
  .init_done (init_done),
  .ev_pre    (ev_pre),
  .ev_ref    (ev_ref),
  .ev_mrs    (ev_mrs)
);

// File: tb/sdram_powerup_seq_test.sv
`timescale 1ns/1ps
module sdram_powerup_seq_test;

  localparam int MHZ = 125;
  localparam int WUS = 1;
  localparam int W   = MHZ * WUS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [10:0] cfg_m, cfg_a;
  logic m_cke, m_cs, m_ras, m_cas, m_we, m_done;
  logic a_cke, a_cs, a_ras, a_cas, a_we, a_done;
  logic [3:0]  m_dqm, a_dqm;
  logic [10:0] m_addr, a_addr;
  logic [1:0]  m_ba, a_ba;

  sdram_powerup_seq #(.CLK_MHZ(MHZ), .WAIT_US(WUS), .T_RP(3), .T_RFC(7), .T_MRD(2),
                      .REFRESH_COUNT(3), .MRS_FIRST(0), .DQM_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .mode_cfg(cfg_m), .sd_cke(m_cke), .sd_cs_n(m_cs),
    .sd_ras_n(m_ras), .sd_cas_n(m_cas), .sd_we_n(m_we), .sd_dqm(m_dqm),
    .sd_addr(m_addr), .sd_ba(m_ba), .init_done(m_done));

  sdram_powerup_seq #(.CLK_MHZ(MHZ), .WAIT_US(WUS), .T_RP(2), .T_RFC(4), .T_MRD(3),
                      .REFRESH_COUNT(1), .MRS_FIRST(1), .DQM_W(4)) uut_alt (
    .clk(clk), .rst_n(rst_n), .mode_cfg(cfg_a), .sd_cke(a_cke), .sd_cs_n(a_cs),
    .sd_ras_n(a_ras), .sd_cas_n(a_cas), .sd_we_n(a_we), .sd_dqm(a_dqm),
    .sd_addr(a_addr), .sd_ba(a_ba), .init_done(a_done));

  bit sel = 1'b0;
  wire       o_cke  = sel ? a_cke  : m_cke;
  wire       o_cs   = sel ? a_cs   : m_cs;
  wire       o_ras  = sel ? a_ras  : m_ras;
  wire       o_cas  = sel ? a_cas  : m_cas;
  wire       o_we   = sel ? a_we   : m_we;
  wire       o_done = sel ? a_done : m_done;
  wire [3:0] o_dqm  = sel ? a_dqm  : m_dqm;
  wire [10:0] o_addr = sel ? a_addr : m_addr;
  wire [1:0]  o_ba   = sel ? a_ba   : m_ba;

  int total = 0;
  int bad = 0;
  int exp_cmd[0:1023];
  int done_idx, n_ref, first_ref, first_mrs;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  // Codes: 0 NOP, 1 precharge, 2 refresh, 3 mode set, 7 illegal.
  function automatic int pin_code();
    if (o_cs) return 7;
    case ({o_ras, o_cas, o_we})
      3'b111: return 0;
      3'b010: return 1;
      3'b001: return 2;
      3'b000: return 3;
      default: return 7;
    endcase
  endfunction

  function automatic logic [10:0] expect_mode(input logic [10:0] raw);
    logic [2:0] cl;
    cl = (raw[6:4] == 3'd2 || raw[6:4] == 3'd3) ? raw[6:4] : 3'd3;
    return {1'b0, raw[9], 2'b00, cl, raw[3:0]};
  endfunction

  task automatic put(inout int idx, input int code, input int gap);
    exp_cmd[idx] = code;
    idx++;
    for (int k = 0; k < gap; k++) begin exp_cmd[idx] = 0; idx++; end
  endtask

  task automatic build(input int rp, input int rfc, input int mrd, input int nref, input bit mfirst);
    int idx = 0;
    for (int k = 0; k < W; k++) begin exp_cmd[idx] = 0; idx++; end
    put(idx, 1, rp);
    if (mfirst) put(idx, 3, mrd);
    for (int k = 0; k < nref; k++) put(idx, 2, rfc);
    if (!mfirst) put(idx, 3, mrd);
    done_idx = idx;
    for (int k = 0; k < 8; k++) exp_cmd[idx + k] = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic trace(input logic [10:0] mode_exp);
    n_ref = 0; first_ref = -1; first_mrs = -1;
    for (int i = 0; i <= done_idx + 6; i++) begin
      int c;
      string t;
      if (i > 0) begin @(negedge clk); #1; end
      c = pin_code();
      if (i < W) t = "R2";
      else if (i >= done_idx) t = "R10";
      else if (exp_cmd[i] == 1) t = "R3";
      else if (exp_cmd[i] == 2) t = "R5";
      else if (exp_cmd[i] == 3) t = "R7";
      else t = "R4";
      check(c == exp_cmd[i], t, c, exp_cmd[i]);
      check(o_cke == 1'b1 && o_dqm == 4'hF, "R11", {o_cke, o_dqm}, 5'h1F);
      check(o_done == (i >= done_idx), "R10", o_done, (i >= done_idx));
      if (c == 1) check(o_addr[10] == 1'b1, "R3", o_addr, 11'h400);
      if (c == 2) begin n_ref++; if (first_ref < 0) first_ref = i; end
      if (c == 3) begin
        if (first_mrs < 0) first_mrs = i;
        check(o_addr == mode_exp && o_ba == 2'b00, "R8", {o_ba, o_addr}, {2'b00, mode_exp});
      end
    end
  endtask

  task automatic test_reset_state();
    sel = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    // R1 during reset
    check(pin_code() == 0 && !o_done, "R1", {pin_code(), o_done}, 0);
    check(o_cke && o_dqm == 4'hF, "R11", {o_cke, o_dqm}, 5'h1F);
    do_reset();
    // R1 first cycle after release
    check(pin_code() == 0 && !o_done, "R1", {pin_code(), o_done}, 0);
  endtask

  task automatic test_main_order();
    sel = 1'b0;
    cfg_m = 11'h7DA;
    build(3, 7, 2, 3, 1'b0);
    do_reset();
    trace(expect_mode(11'h7DA));
    check(n_ref == 3, "R5", n_ref, 3);
    check(first_ref >= 0 && first_mrs > first_ref, "R9", first_mrs, first_ref);
    check(expect_mode(11'h7DA) == 11'h23A, "R8", expect_mode(11'h7DA), 11'h23A);
  endtask

  task automatic test_alt_order();
    sel = 1'b1;
    cfg_a = 11'h7B7;
    build(2, 4, 3, 2, 1'b1);
    do_reset();
    trace(expect_mode(11'h7B7));
    // R6: requested count of 1 raised to 2
    check(n_ref == 2, "R6", n_ref, 2);
    check(first_mrs >= 0 && first_ref > first_mrs, "R9", first_ref, first_mrs);
    check(first_mrs == W + 3, "R9", first_mrs, W + 3);
  endtask

  task automatic test_latency_pass();
    sel = 1'b0;
    cfg_m = 11'h023;
    build(3, 7, 2, 3, 1'b0);
    do_reset();
    trace(11'h023);
    check(first_mrs == W + 4 + 3 * 8, "R8", first_mrs, W + 4 + 3 * 8);
  endtask

  initial begin
    #(8 * 50000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cfg_m = 11'h000;
    cfg_a = 11'h000;
    test_reset_state();
    test_main_order();
    test_alt_order();
    test_latency_pass();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule